// File: doc/BRIEF.md
# Multi-Slave Serial Sample Collector

This block is a serial-bus master that gathers one coherent set of conversion results from three or four isolated ADC slaves. The slaves share one serial clock, one master-out line and one master-in line. Each slave has its own active-low select. Once reset is released, the block writes one configuration byte into every slave. After that it waits for the slaves' data-ready line, which is active low. Each falling edge of that line starts one sweep.

In a sweep the block selects the slaves one at a time, in a fixed order. For each slave it sends a burst-read command byte and clocks in a fixed-length run of output registers. Each run holds the current sample, the first voltage sample, an optional second voltage sample, a checksum, a status byte and a snapshot counter. The runs are collected per slave in a staging store. When the last slave is done, all of them are copied to the parallel outputs at once and a one-cycle completion pulse is given. The next data-ready edge arrives one sample period (125 µs at 8 kHz) later, and the sweep must finish before then. At the fastest legal serial clock (5.6 MHz) the shifting alone takes about 65 µs for three slaves and about 86 µs for four.

Top module: `phase_adc_sweeper`

## Requirements
- R1: While reset is asserted, every select is high, the serial clock is high, the completion pulse and the overrun flag are low, and all result outputs are zero.
- R2: After reset, each slave is selected exactly once, in index order, for a 16-bit write. The first byte is 0x40 (register address 0x08 in bits [7:3], bit 2 clear for a write). The second byte is the `CFG_EXTRA` parameter with bits 5, 4 and 0 forced to 0. This selects the 8 kHz output rate and makes the slave's pin act as data-ready.
- R3: No more than one select is low at any time. Within a sweep the slaves are selected in the order index 0, 1, 2, then 3 when present.
- R4: A falling edge on `drdy_n_i` starts exactly one sweep. The edge is seen after a two-flop synchroniser. A rising edge, or a level held low or high, starts nothing.
- R5: Each sweep access sends the byte 0x04 first, followed by zeros. It is exactly 120 clock pulses long when `HAS_V2` = 1 and 96 pulses long when `HAS_V2` = 0. Data moves MSB first.
- R6: The serial clock idles high. The master changes `mosi_o` on falling edges and samples `miso_i` on rising edges. One serial clock period is `CLK_DIV` system clocks.
- R7: A select goes low at least one serial half-period before the first falling clock edge. It goes high at least one half-period after the last rising edge.
- R8: The bits received after the command byte, MSB first, are split as follows: current sample (24 bits), voltage-1 (24), voltage-2 (24, only when `HAS_V2` = 1), checksum (16), status (8), snapshot count (16). When `HAS_V2` = 0, `v2_o` stays zero.
- R9: `done_o` is a one-cycle pulse after the last slave's access ends. All result outputs change only in that cycle and hold their values until the next pulse.
- R10: A data-ready falling edge that arrives while initialisation or a sweep is in progress sets `overrun_o`. The flag stays set until reset. The edge starts no extra sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_n_i | input | 1 | Data-ready from the last-phase slave, active low |
| miso_i | input | 1 | Shared slave-to-master data |
| sclk_o | output | 1 | Serial clock, idle high |
| mosi_o | output | 1 | Master-to-slave data |
| cs_n_o | output | N_SLAVES | Per-slave select, active low, bit i selects slave i |
| done_o | output | 1 | One-cycle sweep completion pulse |
| overrun_o | output | 1 | Sticky flag: data-ready edge arrived while busy |
| cur_o | output | N_SLAVES*24 | Current samples, slave i at bits [24i+23:24i] |
| v1_o | output | N_SLAVES*24 | Voltage-1 samples |
| v2_o | output | N_SLAVES*24 | Voltage-2 samples (zero when absent) |
| crc_o | output | N_SLAVES*16 | Checksum words |
| stat_o | output | N_SLAVES*8 | Status bytes |
| cnt_o | output | N_SLAVES*16 | Snapshot counters |

## Verification
The hardest case to reach from the ports is a second data-ready edge that lands in the middle of a sweep. It must raise the overrun flag without disturbing the sweep in progress, and the later release of the line must start nothing. To get there, the stimulus lowers data-ready, releases it, and lowers it again about two hundred cycles into the sweep, while a select is still active. It then holds the line low past completion and finally raises it. Each slave's frame count and the completion count are watched for the whole time. A second instance with three slaves and no second voltage channel checks the shorter 96-bit access and the layout of its fields.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  localparam logic [7:0] BURST_RD_CMD   = 8'h04;
  localparam logic [4:0] CFG_REG_ADDR   = 5'h08;
  localparam logic [7:0] CFG_WR_CMD     = {CFG_REG_ADDR, 3'b000};
  // rate field [5:4] and pin-function bit [0] are forced to zero
  localparam logic [7:0] CFG_KEEP_MASK  = 8'hCE;

  localparam int CMD_W          = 8;
  localparam int SAMPLE_W       = 24;
  localparam int CRC_W          = 16;
  localparam int STAT_W         = 8;
  localparam int CNT_W          = 16;
  localparam int CFG_FRAME_BITS = 16;

  typedef enum logic [2:0] {
    E_IDLE, E_SETUP, E_LOW, E_HIGH, E_HOLD, E_GAP
  } eng_state_t;

  typedef enum logic [2:0] {
    C_INIT, C_INIT_WAIT, C_IDLE, C_RD, C_RD_WAIT, C_COMMIT
  } seq_state_t;

  function automatic int burst_bits(input bit has_v2);
    return SAMPLE_W * (has_v2 ? 3 : 2) + CRC_W + STAT_W + CNT_W;
  endfunction

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sweep_drdy_edge.sv
module sweep_drdy_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n_i,
  output logic fall_o
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= drdy_n_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign fall_o = prev_q & ~sync2_q;
endmodule

// File: rtl/sweep_spi_engine.sv
module sweep_spi_engine
  import sweep_pkg::*;
#(
  parameter int FRAME_W = 120,
  parameter int RX_W    = 112,
  parameter int CLK_DIV = 4,
  parameter int N_CS    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic [sel_width(N_CS)-1:0]         cs_sel_i,
  input  logic [$clog2(FRAME_W+1)-1:0]       nbits_i,
  input  logic [FRAME_W-1:0]                 tx_i,
  input  logic                               miso_i,
  output logic                               sclk_o,
  output logic                               mosi_o,
  output logic [N_CS-1:0]                    cs_n_o,
  output logic                               done_o,
  output logic [RX_W-1:0]                    rx_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int HC_W  = $clog2(HALF) + 1;
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam logic [HC_W-1:0] HC_RELOAD = HC_W'(HALF - 1);

  eng_state_t          st_q, st_d;
  logic [HC_W-1:0]     hc_q, hc_d;
  logic [BIT_W-1:0]    bits_q, bits_d;
  logic [FRAME_W-1:0]  sh_q, sh_d;
  logic                sclk_q, sclk_d, mosi_q, mosi_d, done_q, done_d;
  logic [N_CS-1:0]     cs_n_q, cs_n_d;
  logic                hc_zero;

  assign hc_zero = (hc_q == '0);

  always_comb begin
    st_d   = st_q;
    bits_d = bits_q;
    sh_d   = sh_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    cs_n_d = cs_n_q;
    done_d = 1'b0;
    hc_d   = (st_q == E_IDLE || hc_zero) ? HC_RELOAD : hc_q - 1'b1;
    unique case (st_q)
      E_IDLE: if (start_i) begin
        st_d   = E_SETUP;
        sh_d   = tx_i;
        bits_d = nbits_i;
        cs_n_d = '1;
        cs_n_d[cs_sel_i] = 1'b0;
      end
      E_SETUP: if (hc_zero) begin
        st_d   = E_LOW;
        sclk_d = 1'b0;
        mosi_d = sh_q[FRAME_W-1];
      end
      E_LOW: if (hc_zero) begin
        st_d   = E_HIGH;
        sclk_d = 1'b1;
        sh_d   = {sh_q[FRAME_W-2:0], miso_i};
        bits_d = bits_q - 1'b1;
      end
      E_HIGH: if (hc_zero) begin
        if (bits_q == '0) begin
          st_d = E_HOLD;
        end else begin
          st_d   = E_LOW;
          sclk_d = 1'b0;
          mosi_d = sh_q[FRAME_W-1];
        end
      end
      E_HOLD: if (hc_zero) begin
        st_d   = E_GAP;
        cs_n_d = '1;
        mosi_d = 1'b0;
      end
      E_GAP: if (hc_zero) begin
        st_d   = E_IDLE;
        done_d = 1'b1;
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      hc_q   <= '0;
      bits_q <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
      cs_n_q <= '1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hc_q   <= hc_d;
      bits_q <= bits_d;
      sh_q   <= sh_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      cs_n_q <= cs_n_d;
      done_q <= done_d;
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign cs_n_o = cs_n_q;
  assign done_o = done_q;
  assign rx_o   = sh_q[RX_W-1:0];
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int          N_SLAVES  = 4,
  parameter int          FRAME_W   = 120,
  parameter logic [7:0]  CFG_EXTRA = 8'h00
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              fall_i,
  input  logic                              eng_done_i,
  output logic                              eng_start_o,
  output logic [sel_width(N_SLAVES)-1:0]    eng_sel_o,
  output logic [$clog2(FRAME_W+1)-1:0]      eng_nbits_o,
  output logic [FRAME_W-1:0]                eng_tx_o,
  output logic                              cap_o,
  output logic                              commit_o,
  output logic                              overrun_o
);
  localparam int IDX_W = sel_width(N_SLAVES);
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLAVES - 1);
  localparam logic [7:0] CFG_BYTE = CFG_EXTRA & CFG_KEEP_MASK;

  seq_state_t        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              ovr_q, ovr_d;
  logic              in_init;

  assign in_init = (st_q == C_INIT) || (st_q == C_INIT_WAIT);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    ovr_d = ovr_q | (fall_i && st_q != C_IDLE);
    unique case (st_q)
      C_INIT:      st_d = C_INIT_WAIT;
      C_INIT_WAIT: if (eng_done_i) begin
        if (idx_q == LAST_IDX) begin
          idx_d = '0;
          st_d  = C_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = C_INIT;
        end
      end
      C_IDLE:      if (fall_i) st_d = C_RD;
      C_RD:        st_d = C_RD_WAIT;
      C_RD_WAIT:   if (eng_done_i) begin
        if (idx_q == LAST_IDX) begin
          st_d = C_COMMIT;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = C_RD;
        end
      end
      C_COMMIT: begin
        idx_d = '0;
        st_d  = C_IDLE;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_INIT;
      idx_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      ovr_q <= ovr_d;
    end
  end

  assign eng_start_o = (st_q == C_INIT) || (st_q == C_RD);
  assign eng_sel_o   = idx_q;
  assign eng_nbits_o = in_init ? BIT_W'(CFG_FRAME_BITS) : BIT_W'(FRAME_W);
  assign eng_tx_o    = in_init ? {CFG_WR_CMD, CFG_BYTE, {(FRAME_W-16){1'b0}}}
                               : {BURST_RD_CMD, {(FRAME_W-8){1'b0}}};
  assign cap_o       = (st_q == C_RD_WAIT) && eng_done_i;
  assign commit_o    = (st_q == C_COMMIT);
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/sweep_result_bank.sv
module sweep_result_bank
  import sweep_pkg::*;
#(
  parameter int N_SLAVES = 4,
  parameter bit HAS_V2   = 1'b1,
  parameter int DW       = 112
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cap_i,
  input  logic [sel_width(N_SLAVES)-1:0]     cap_idx_i,
  input  logic [DW-1:0]                      rx_i,
  input  logic                               commit_i,
  output logic                               done_o,
  output logic [N_SLAVES*SAMPLE_W-1:0]       cur_o,
  output logic [N_SLAVES*SAMPLE_W-1:0]       v1_o,
  output logic [N_SLAVES*SAMPLE_W-1:0]       v2_o,
  output logic [N_SLAVES*CRC_W-1:0]          crc_o,
  output logic [N_SLAVES*STAT_W-1:0]         stat_o,
  output logic [N_SLAVES*CNT_W-1:0]          cnt_o
);
  localparam int IDX_W  = sel_width(N_SLAVES);
  localparam int CNT_LO = 0;
  localparam int ST_LO  = CNT_LO + CNT_W;
  localparam int CRC_LO = ST_LO + STAT_W;

  logic [DW-1:0] stage_q [N_SLAVES];
  logic [DW-1:0] hold_q  [N_SLAVES];
  logic          done_q;

  for (genvar s = 0; s < N_SLAVES; s++) begin : g_slot
    logic stage_en;
    assign stage_en = cap_i && (cap_idx_i == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
        hold_q[s]  <= '0;
      end else begin
        if (stage_en) stage_q[s] <= rx_i;
        if (commit_i) hold_q[s]  <= stage_q[s];
      end
    end

    assign cur_o [s*SAMPLE_W +: SAMPLE_W] = hold_q[s][DW-1 -: SAMPLE_W];
    assign v1_o  [s*SAMPLE_W +: SAMPLE_W] = hold_q[s][DW-1-SAMPLE_W -: SAMPLE_W];
    if (HAS_V2) begin : g_v2
      assign v2_o[s*SAMPLE_W +: SAMPLE_W] = hold_q[s][DW-1-2*SAMPLE_W -: SAMPLE_W];
    end else begin : g_no_v2
      assign v2_o[s*SAMPLE_W +: SAMPLE_W] = '0;
    end
    assign crc_o [s*CRC_W  +: CRC_W]  = hold_q[s][CRC_LO +: CRC_W];
    assign stat_o[s*STAT_W +: STAT_W] = hold_q[s][ST_LO +: STAT_W];
    assign cnt_o [s*CNT_W  +: CNT_W]  = hold_q[s][CNT_LO +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= commit_i;
  end

  assign done_o = done_q;
endmodule

// File: rtl/phase_adc_sweeper.sv
module phase_adc_sweeper
  import sweep_pkg::*;
#(
  parameter int         N_SLAVES  = 4,
  parameter bit         HAS_V2    = 1'b1,
  parameter int         CLK_DIV   = 4,
  parameter logic [7:0] CFG_EXTRA = 8'h00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          drdy_n_i,
  input  logic                          miso_i,
  output logic                          sclk_o,
  output logic                          mosi_o,
  output logic [N_SLAVES-1:0]           cs_n_o,
  output logic                          done_o,
  output logic                          overrun_o,
  output logic [N_SLAVES*24-1:0]        cur_o,
  output logic [N_SLAVES*24-1:0]        v1_o,
  output logic [N_SLAVES*24-1:0]        v2_o,
  output logic [N_SLAVES*16-1:0]        crc_o,
  output logic [N_SLAVES*8-1:0]         stat_o,
  output logic [N_SLAVES*16-1:0]        cnt_o
);
  localparam int DW      = burst_bits(HAS_V2);
  localparam int FRAME_W = DW + CMD_W;
  localparam int IDX_W   = sel_width(N_SLAVES);
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  logic               fall;
  logic               eng_start, eng_done, cap, commit;
  logic [IDX_W-1:0]   eng_sel;
  logic [BIT_W-1:0]   eng_nbits;
  logic [FRAME_W-1:0] eng_tx;
  logic [DW-1:0]      rx_word;

  sweep_drdy_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .drdy_n_i (drdy_n_i),
    .fall_o   (fall)
  );

  sweep_ctrl #(
    .N_SLAVES  (N_SLAVES),
    .FRAME_W   (FRAME_W),
    .CFG_EXTRA (CFG_EXTRA)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_i      (fall),
    .eng_done_i  (eng_done),
    .eng_start_o (eng_start),
    .eng_sel_o   (eng_sel),
    .eng_nbits_o (eng_nbits),
    .eng_tx_o    (eng_tx),
    .cap_o       (cap),
    .commit_o    (commit),
    .overrun_o   (overrun_o)
  );

  sweep_spi_engine #(
    .FRAME_W (FRAME_W),
    .RX_W    (DW),
    .CLK_DIV (CLK_DIV),
    .N_CS    (N_SLAVES)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (eng_start),
    .cs_sel_i (eng_sel),
    .nbits_i  (eng_nbits),
    .tx_i     (eng_tx),
    .miso_i   (miso_i),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .cs_n_o   (cs_n_o),
    .done_o   (eng_done),
    .rx_o     (rx_word)
  );

  sweep_result_bank #(
    .N_SLAVES (N_SLAVES),
    .HAS_V2   (HAS_V2),
    .DW       (DW)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cap),
    .cap_idx_i (eng_sel),
    .rx_i      (rx_word),
    .commit_i  (commit),
    .done_o    (done_o),
    .cur_o     (cur_o),
    .v1_o      (v1_o),
    .v2_o      (v2_o),
    .crc_o     (crc_o),
    .stat_o    (stat_o),
    .cnt_o     (cnt_o)
  );
endmodule

// File: rtl/phase_adc_sweeper_checker.sv
module phase_adc_sweeper_checker #(
  parameter int N_SLAVES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sclk_o,
  input logic [N_SLAVES-1:0]    cs_n_o,
  input logic                   done_o,
  input logic                   overrun_o,
  input logic [N_SLAVES*24-1:0] cur_o,
  input logic [N_SLAVES*16-1:0] cnt_o
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o)); // R3

  AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n_o) |-> sclk_o); // R6

  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $past(~&cs_n_o)); // R7

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n_o) |-> (sclk_o && $past(sclk_o))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(cur_o) && $stable(cnt_o))); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o); // R10
endmodule

bind phase_adc_sweeper phase_adc_sweeper_checker #(.N_SLAVES(N_SLAVES)) i_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk_o    (sclk_o),
  .cs_n_o    (cs_n_o),
  .done_o    (done_o),
  .overrun_o (overrun_o),
  .cur_o     (cur_o),
  .cnt_o     (cnt_o)
);

// File: tb/test_phase_adc_sweeper.sv
module adc_slave_model #(
  parameter int DW = 112
) (
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [DW-1:0] pattern,
  output logic          miso,
  output int            frames,
  output int            last_count,
  output logic [127:0]  last_rx
);
  int           fcnt, rcnt;
  logic [127:0] rsh;
  bit           armed;

  initial begin
    miso = 1'b0; frames = 0; last_count = 0; last_rx = '0;
    fcnt = 0; rcnt = 0; rsh = '0; armed = 1'b0;
  end

  always @(negedge cs_n) begin
    fcnt = 0; rcnt = 0; rsh = '0; armed = 1'b1;
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      if (fcnt >= 8 && fcnt - 8 < DW) miso = pattern[DW-1-(fcnt-8)];
      else miso = 1'b0;
      fcnt++;
    end
  end

  always @(posedge sclk) begin
    if (cs_n === 1'b0) begin
      rsh = {rsh[126:0], mosi};
      rcnt++;
    end
  end

  always @(posedge cs_n) begin
    if (armed) begin
      frames++; last_count = rcnt; last_rx = rsh; armed = 1'b0;
    end
  end
endmodule

module test_phase_adc_sweeper;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NA = 4;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drdy_n = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic sclk_a, mosi_a, done_a, ovr_a, miso_a;
  logic [NA-1:0] cs_n_a;
  logic [NA*24-1:0] cur_a, v1_a, v2_a;
  logic [NA*16-1:0] crc_a, cnt_a;
  logic [NA*8-1:0]  st_a;

  logic sclk_b, mosi_b, done_b, ovr_b, miso_b;
  logic [NB-1:0] cs_n_b;
  logic [NB*24-1:0] cur_b, v1_b, v2_b;
  logic [NB*16-1:0] crc_b, cnt_b;
  logic [NB*8-1:0]  st_b;

  phase_adc_sweeper #(.N_SLAVES(NA), .HAS_V2(1'b1), .CLK_DIV(DIV), .CFG_EXTRA(8'hF3))
  i_phase_adc_sweeper (
    .clk(clk), .rst_n(rst_n), .drdy_n_i(drdy_n), .miso_i(miso_a),
    .sclk_o(sclk_a), .mosi_o(mosi_a), .cs_n_o(cs_n_a), .done_o(done_a),
    .overrun_o(ovr_a), .cur_o(cur_a), .v1_o(v1_a), .v2_o(v2_a),
    .crc_o(crc_a), .stat_o(st_a), .cnt_o(cnt_a));

  phase_adc_sweeper #(.N_SLAVES(NB), .HAS_V2(1'b0), .CLK_DIV(DIV), .CFG_EXTRA(8'hFF))
  i_phase_adc_sweeper_b (
    .clk(clk), .rst_n(rst_n), .drdy_n_i(drdy_n), .miso_i(miso_b),
    .sclk_o(sclk_b), .mosi_o(mosi_b), .cs_n_o(cs_n_b), .done_o(done_b),
    .overrun_o(ovr_b), .cur_o(cur_b), .v1_o(v1_b), .v2_o(v2_b),
    .crc_o(crc_b), .stat_o(st_b), .cnt_o(cnt_b));

  logic [111:0] pat_a [NA];
  logic [87:0]  pat_b [NB];
  logic         ms_a [NA];
  logic         ms_b [NB];
  int           fr_a [NA], lc_a [NA], fr_b [NB], lc_b [NB];
  logic [127:0] lr_a [NA], lr_b [NB];

  for (genvar k = 0; k < NA; k++) begin : g_sa
    adc_slave_model #(.DW(112)) u_m (.sclk(sclk_a), .cs_n(cs_n_a[k]), .mosi(mosi_a),
      .pattern(pat_a[k]), .miso(ms_a[k]), .frames(fr_a[k]),
      .last_count(lc_a[k]), .last_rx(lr_a[k]));
  end
  for (genvar k = 0; k < NB; k++) begin : g_sb
    adc_slave_model #(.DW(88)) u_m (.sclk(sclk_b), .cs_n(cs_n_b[k]), .mosi(mosi_b),
      .pattern(pat_b[k]), .miso(ms_b[k]), .frames(fr_b[k]),
      .last_count(lc_b[k]), .last_rx(lr_b[k]));
  end

  always_comb begin
    miso_a = 1'b0;
    for (int k = 0; k < NA; k++) if (cs_n_a[k] == 1'b0) miso_a = miso_a | ms_a[k];
    miso_b = 1'b0;
    for (int k = 0; k < NB; k++) if (cs_n_b[k] == 1'b0) miso_b = miso_b | ms_b[k];
  end

  // selection order log for instance A
  int ord [64];
  int ord_n = 0;
  for (genvar k = 0; k < NA; k++) begin : g_ord
    always @(negedge cs_n_a[k]) if (ord_n < 64) begin ord[ord_n] = k; ord_n++; end
  end

  // done pulse monitor
  int ndone_a = 0, ndone_b = 0, dbl = 0;
  logic pd_a = 1'b0;
  always @(negedge clk) begin
    if (done_a) ndone_a++;
    if (done_b) ndone_b++;
    if (done_a && pd_a) dbl++;
    pd_a = done_a;
  end

  // serial timing monitor on instance A
  time t_rise = 0, t_prev_rise = 0, t_sel = 0;
  time min_setup = 1000000, min_hold = 1000000;
  bit  first_fall = 1'b0;
  always @(posedge sclk_a) begin t_prev_rise = t_rise; t_rise = $time; end
  always @(negedge sclk_a) if (first_fall) begin
    if ($time - t_sel < min_setup) min_setup = $time - t_sel;
    first_fall = 1'b0;
  end
  always @(cs_n_a) if (rst_n) begin
    if (cs_n_a != '1) begin t_sel = $time; first_fall = 1'b1; end
    else if ($time - t_rise < min_hold) min_hold = $time - t_rise;
  end

  int errors = 0, checks = 0;
  int exp_fr = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [111:0] make_pat(input int seed, input int s);
    logic [111:0] p;
    for (int i = 0; i < 14; i++) p[i*8 +: 8] = 8'((seed*29 + s*53 + i*7 + 1) & 255);
    return p;
  endfunction

  task automatic load_pats(input int seed);
    for (int s = 0; s < NA; s++) pat_a[s] = make_pat(seed, s);
    for (int s = 0; s < NB; s++) pat_b[s] = make_pat(seed, s + 8)[87:0];
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_done(input int target);
    int n = 0;
    while ((ndone_a < target || ndone_b < target) && n < 10000) begin
      @(negedge clk); n++;
    end
    check(n < 10000, "R9", "sweep completion", 128'(ndone_a), 128'(target));
  endtask

  task automatic pulse_drdy();
    @(negedge clk) drdy_n = 1'b0;
    repeat (40) @(negedge clk);
    drdy_n = 1'b1;
  endtask

  task automatic check_fields(input int seed, input string tag);
    for (int s = 0; s < NA; s++) begin
      logic [111:0] p;
      p = make_pat(seed, s);
      check(cur_a[s*24 +: 24] == p[111:88], tag, "A current", 128'(cur_a[s*24 +: 24]), 128'(p[111:88]));
      check(v1_a[s*24 +: 24]  == p[87:64],  tag, "A volt1",   128'(v1_a[s*24 +: 24]),  128'(p[87:64]));
      check(v2_a[s*24 +: 24]  == p[63:40],  tag, "A volt2",   128'(v2_a[s*24 +: 24]),  128'(p[63:40]));
      check(crc_a[s*16 +: 16] == p[39:24],  tag, "A crc",     128'(crc_a[s*16 +: 16]), 128'(p[39:24]));
      check(st_a[s*8 +: 8]    == p[23:16],  tag, "A status",  128'(st_a[s*8 +: 8]),    128'(p[23:16]));
      check(cnt_a[s*16 +: 16] == p[15:0],   tag, "A count",   128'(cnt_a[s*16 +: 16]), 128'(p[15:0]));
    end
    for (int s = 0; s < NB; s++) begin
      logic [87:0] q;
      q = make_pat(seed, s + 8)[87:0];
      check(cur_b[s*24 +: 24] == q[87:64], tag, "B current", 128'(cur_b[s*24 +: 24]), 128'(q[87:64]));
      check(v1_b[s*24 +: 24]  == q[63:40], tag, "B volt1",   128'(v1_b[s*24 +: 24]),  128'(q[63:40]));
      check(v2_b[s*24 +: 24]  == '0,       tag, "B volt2 absent", 128'(v2_b[s*24 +: 24]), 128'(0));
      check(crc_b[s*16 +: 16] == q[39:24], tag, "B crc",     128'(crc_b[s*16 +: 16]), 128'(q[39:24]));
      check(st_b[s*8 +: 8]    == q[23:16], tag, "B status",  128'(st_b[s*8 +: 8]),    128'(q[23:16]));
      check(cnt_b[s*16 +: 16] == q[15:0],  tag, "B count",   128'(cnt_b[s*16 +: 16]), 128'(q[15:0]));
    end
  endtask

  task automatic check_frames(input string tag);
    for (int s = 0; s < NA; s++) begin
      check(fr_a[s] == exp_fr, tag, "A frames per slave", 128'(fr_a[s]), 128'(exp_fr));
      check(lc_a[s] == 120, "R5", "A access length", 128'(lc_a[s]), 128'(120));
      check(lr_a[s][119:0] == {8'h04, 112'h0}, "R5", "A command then zeros",
            lr_a[s][119:0], {8'h04, 112'h0});
    end
    for (int s = 0; s < NB; s++) begin
      check(fr_b[s] == exp_fr, tag, "B frames per slave", 128'(fr_b[s]), 128'(exp_fr));
      check(lc_b[s] == 96, "R5", "B access length", 128'(lc_b[s]), 128'(96));
      check(lr_b[s][95:0] == {8'h04, 88'h0}, "R5", "B command then zeros",
            lr_b[s][95:0], {8'h04, 88'h0});
    end
  endtask

  task automatic check_order();
    for (int j = 0; j < NA; j++)
      check(ord[ord_n-NA+j] == j, "R3", "select order", 128'(ord[ord_n-NA+j]), 128'(j));
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(cs_n_a == '1, "R1", "selects idle in reset", 128'(cs_n_a), 128'(4'hF));
    check(sclk_a == 1'b1, "R1", "clock high in reset", 128'(sclk_a), 128'(1));
    check(done_a == 1'b0, "R1", "done low in reset", 128'(done_a), 128'(0));
    check(ovr_a == 1'b0, "R1", "overrun low in reset", 128'(ovr_a), 128'(0));
    check(cur_a == '0 && cnt_a == '0, "R1", "results zero in reset", 128'(cur_a), 128'(0));
  endtask

  task automatic t_init();
    repeat (800) @(negedge clk);
    exp_fr = 1;
    for (int s = 0; s < NA; s++) begin
      check(fr_a[s] == 1, "R2", "A one init frame", 128'(fr_a[s]), 128'(1));
      check(lc_a[s] == 16 && lr_a[s][15:0] == 16'h40C2, "R2", "A config write",
            lr_a[s][15:0], 128'(16'h40C2));
    end
    for (int s = 0; s < NB; s++) begin
      check(fr_b[s] == 1, "R2", "B one init frame", 128'(fr_b[s]), 128'(1));
      check(lc_b[s] == 16 && lr_b[s][15:0] == 16'h40CE, "R2", "B config write",
            lr_b[s][15:0], 128'(16'h40CE));
    end
    check_order();
    check(ndone_a == 0, "R9", "no done during init", 128'(ndone_a), 128'(0));
  endtask

  task automatic t_sweep(input int seed, input int target);
    load_pats(seed);
    pulse_drdy();
    wait_done(target);
    repeat (4) @(negedge clk);
    exp_fr++;
    check_frames("R4");
    check_fields(seed, "R8");
    check_order();
    check(ovr_a == 1'b0, "R10", "no overrun on clean sweep", 128'(ovr_a), 128'(0));
    check(dbl == 0, "R9", "done one cycle", 128'(dbl), 128'(0));
  endtask

  task automatic t_hold_and_timing(input int old_seed);
    load_pats(old_seed + 1);
    repeat (600) @(negedge clk);
    check_fields(old_seed, "R9");
    check(t_rise - t_prev_rise == DIV*CLK_PERIOD, "R6", "serial clock period",
          128'(t_rise - t_prev_rise), 128'(DIV*CLK_PERIOD));
    check(min_setup >= (DIV/2)*CLK_PERIOD, "R7", "select setup", 128'(min_setup),
          128'((DIV/2)*CLK_PERIOD));
    check(min_hold >= (DIV/2)*CLK_PERIOD, "R7", "select hold", 128'(min_hold),
          128'((DIV/2)*CLK_PERIOD));
  endtask

  task automatic t_overrun(input int seed, input int target);
    load_pats(seed);
    @(negedge clk) drdy_n = 1'b0;
    repeat (10) @(negedge clk);
    drdy_n = 1'b1;
    repeat (190) @(negedge clk);
    drdy_n = 1'b0;                 // second edge while busy
    wait_done(target);
    repeat (4) @(negedge clk);
    exp_fr++;
    check(ovr_a == 1'b1, "R10", "A overrun set", 128'(ovr_a), 128'(1));
    check(ovr_b == 1'b1, "R10", "B overrun set", 128'(ovr_b), 128'(1));
    check_frames("R10");
    check_fields(seed, "R10");
    repeat (3000) @(negedge clk);
    check(ndone_a == target, "R10", "no extra sweep from busy edge", 128'(ndone_a), 128'(target));
    check(fr_a[0] == exp_fr, "R4", "held low starts nothing", 128'(fr_a[0]), 128'(exp_fr));
    drdy_n = 1'b1;
    repeat (3000) @(negedge clk);
    check(ndone_a == target, "R4", "rising edge starts nothing", 128'(ndone_a), 128'(target));
    check(fr_a[NA-1] == exp_fr, "R4", "no frames after rise", 128'(fr_a[NA-1]), 128'(exp_fr));
    check(ovr_a == 1'b1, "R10", "overrun sticky", 128'(ovr_a), 128'(1));
  endtask

  initial begin
    int n = 0;
    while (n < 150000) begin @(posedge clk); n++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    load_pats(0);
    t_reset_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_init();
    t_sweep(1, 1);
    t_sweep(2, 2);
    t_hold_and_timing(2);
    t_overrun(4, 3);
    summary();
  end
endmodule